// File: doc/BRIEF.md
# Serial Controller Register Bank

This block is the software-facing side of a byte-oriented serial port. A 32-bit register bus gives access to line control, line status, interrupt enable, interrupt status, FIFO control and baud divisor registers, plus a transmit-data word and a receive-data word. Two 16-entry byte FIFOs sit behind the data words. The transmit FIFO drains into a byte-stream output, and a byte-stream input fills the receive FIFO. Framing and bit timing are left to whatever is attached to the streams.

The bus is a single-cycle access port. `bus_word` selects a 32-bit word, so the byte offset is four times `bus_word`. `bus_be` selects byte lanes in big-endian order. A write takes effect at the clock edge where `bus_en` and `bus_we` are both high. A read samples its word at the edge where `bus_en` is high and `bus_we` is low, and the word appears on `bus_rdata` after that edge. Both streams follow valid/ready rules: a byte moves on an edge where valid and ready are both high. `tx_valid` and `tx_data` stay put until they are taken, unless software flushes the transmit FIFO. `rx_ready` drops while the receive FIFO holds 16 bytes, and the source must then hold its byte.

Two sticky status flags record that the receive FIFO has data and that the transmit FIFO is empty. Software clears a flag by writing 0 to its bit. The interrupt output is a level: it is high while any status flag is set whose enable bit is also set.

Top module: `sio_regbank`

## Requirements
- R1: Word 0 is line control, word 1 line status, word 2 interrupt enable, word 3 interrupt status, word 4 FIFO control, word 5 baud divisor, word 8 transmit data and word 12 receive data. All other words read 0 and ignore writes.
- R2: Writes are limited to the bits in these masks: line control 0xE17F0000, interrupt enable 0x000F0000, FIFO control 0x001F0000, baud divisor 0x03FF0000. Line status always reads 0.
- R3: After reset, line control reads 0x40000000 and baud divisor reads 0x03FF0000. Every other register reads 0 and both FIFOs are empty. The only exception is the transmit-empty flag, which sets on the first edge after reset.
- R4: `bus_be[3]` maps to bits 31:24, which is the lowest byte address, and `bus_be[0]` maps to bits 7:0. A write changes only the enabled lanes. A read returns 0 in every lane that is not enabled.
- R5: A write to word 8 with `bus_be[3]` set pushes bits 31:24 into the transmit FIFO. A write to word 8 without `bus_be[3]` does nothing, and word 8 reads 0. `tx_valid` is high while the transmit FIFO holds data, and `tx_data` shows the oldest byte, held stable until it is accepted.
- R6: A read of word 12 with `bus_be[3]` set pops the oldest received byte and returns it in bits 31:24. A read with the FIFO empty, or a read without `bus_be[3]`, returns 0 and pops nothing.
- R7: Each FIFO holds 16 bytes. `rx_ready` is low while the receive FIFO is full. A write to word 8 while the transmit FIFO is full is dropped.
- R8: Status bit 16 sets on any edge where the receive FIFO is non-empty. Status bit 17 sets on any edge where the transmit FIFO is empty. Both bits stay set after their condition ends. Bit 18 is never set by hardware.
- R9: A write to word 3 clears every status bit in an enabled lane that is written as 0, and leaves bits written as 1 unchanged. The clear wins on that edge. If the condition behind a cleared flag still holds, the flag sets again on the next edge.
- R10: `irq` is high exactly while status bits 18:16 ANDed with interrupt-enable bits 18:16 are non-zero.
- R11: Interrupt-enable bit 19 requests DMA, which is not supported. `dma_err` is high while that bit is set.
- R12: A FIFO control write flushes the receive FIFO when bit 17 is set and the transmit FIFO when bit 18 is set, in both cases only if bit 16 (flush enable) is also set in the value written. A flush overrides any push or pop on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_en | input | 1 | Access strobe for this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_word | input | 6 | Word index (byte offset / 4) |
| bus_be | input | 4 | Byte-lane enables, bit 3 = bits 31:24 |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| tx_valid | output | 1 | Transmit byte available |
| tx_ready | input | 1 | Line side accepts the transmit byte |
| tx_data | output | 8 | Oldest transmit byte |
| rx_valid | input | 1 | Line side offers a received byte |
| rx_ready | output | 1 | Receive FIFO has room |
| rx_data | input | 8 | Received byte |
| irq | output | 1 | Level interrupt |
| dma_err | output | 1 | Unsupported DMA enable is set |

## Verification
Most internal faults in this block reach the ports within one or two edges. A wrong FIFO pointer or count shows up as a byte in the wrong order, a lost or repeated byte, or an early drop of `rx_ready`, and these are visible on the next stream transfer or receive-data read. A flag that fails to set or re-set is visible on the status read that follows, and on `irq` in the same cycle. A faulty write mask or reset value is caught by the next read of that word, which is why all 64 word slots are swept both after reset and after an all-ones write.

// File: rtl/sio_pkg.sv
package sio_pkg;
  localparam int DATA_W  = 32;
  localparam int WORD_AW = 6;
  localparam int LANES   = DATA_W / 8;

  localparam logic [WORD_AW-1:0] W_LINE = 6'd0;
  localparam logic [WORD_AW-1:0] W_LST  = 6'd1;
  localparam logic [WORD_AW-1:0] W_IEN  = 6'd2;
  localparam logic [WORD_AW-1:0] W_STAT = 6'd3;
  localparam logic [WORD_AW-1:0] W_FCTL = 6'd4;
  localparam logic [WORD_AW-1:0] W_BAUD = 6'd5;
  localparam logic [WORD_AW-1:0] W_TXD  = 6'd8;
  localparam logic [WORD_AW-1:0] W_RXD  = 6'd12;

  localparam logic [DATA_W-1:0] LINE_MASK = 32'hE17F_0000;
  localparam logic [DATA_W-1:0] IEN_MASK  = 32'h000F_0000;
  localparam logic [DATA_W-1:0] FCTL_MASK = 32'h001F_0000;
  localparam logic [DATA_W-1:0] BAUD_MASK = 32'h03FF_0000;
  localparam logic [DATA_W-1:0] LINE_RST  = 32'h4000_0000;
  localparam logic [DATA_W-1:0] BAUD_RST  = 32'h03FF_0000;

  // flag and control bit positions that neighbouring logic decodes
  localparam int FLG_LO   = 16;
  localparam int N_FLAGS  = 3;
  localparam int N_IEN    = 4;
  localparam int IEN_DMA  = 19;
  localparam int FC_ENA   = 16;
  localparam int FC_RXCLR = 17;
  localparam int FC_TXCLR = 18;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_LINE, SEL_LST, SEL_IEN, SEL_STAT,
    SEL_FCTL, SEL_BAUD, SEL_TXD, SEL_RXD
  } reg_sel_e;

  function automatic reg_sel_e word_decode(input logic [WORD_AW-1:0] w);
    case (w)
      W_LINE:  return SEL_LINE;
      W_LST:   return SEL_LST;
      W_IEN:   return SEL_IEN;
      W_STAT:  return SEL_STAT;
      W_FCTL:  return SEL_FCTL;
      W_BAUD:  return SEL_BAUD;
      W_TXD:   return SEL_TXD;
      W_RXD:   return SEL_RXD;
      default: return SEL_NONE;
    endcase
  endfunction
endpackage

// File: rtl/sio_fifo.sv
module sio_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic [CW-1:0]    count,
  output logic             empty,
  output logic             full
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [CW-1:0]    cnt_q;
  logic             do_push, do_pop;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CW'(DEPTH));
  assign count   = cnt_q;
  assign head    = mem[rd_ptr];
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt_q  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt_q  <= '0;
    end else begin
      if (do_push) wr_ptr <= bump(wr_ptr);
      if (do_pop)  rd_ptr <= bump(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (do_push && !flush) mem[wr_ptr] <= push_data;
  end
endmodule

// File: rtl/sio_flags.sv
module sio_flags #(
  parameter int NF = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NF-1:0] cond,
  input  logic [NF-1:0] clr,
  output logic [NF-1:0] flag
);
  for (genvar i = 0; i < NF; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      flag[i] <= 1'b0;
      else if (clr[i]) flag[i] <= 1'b0;
      else if (cond[i]) flag[i] <= 1'b1;
    end
  end
endmodule

// File: rtl/sio_csr.sv
module sio_csr
  import sio_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_en,
  input  logic               bus_we,
  input  logic [WORD_AW-1:0] bus_word,
  input  logic [LANES-1:0]   bus_be,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  input  logic [N_FLAGS-1:0] flags,
  output logic [N_FLAGS-1:0] flag_clr,
  output logic [N_IEN-1:0]   ien,
  output logic               tx_push,
  output logic [7:0]         tx_byte,
  output logic               tx_flush,
  input  logic               rx_empty,
  input  logic [7:0]         rx_head,
  output logic               rx_pop,
  output logic               rx_flush
);
  logic [DATA_W-1:0] lane_m;
  logic [DATA_W-1:0] line_q, ien_q, fctl_q, baud_q, fctl_nx, rd_word;
  logic [DATA_W-1:0] stat_word;
  reg_sel_e          sel;
  logic              wr, rd;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign lane_m[l*8 +: 8] = {8{bus_be[l]}};
  end

  assign sel = word_decode(bus_word);
  assign wr  = bus_en && bus_we;
  assign rd  = bus_en && !bus_we;

  function automatic logic [DATA_W-1:0] merge(input logic [DATA_W-1:0] old,
                                              input logic [DATA_W-1:0] wd,
                                              input logic [DATA_W-1:0] lm,
                                              input logic [DATA_W-1:0] msk);
    return ((old & ~lm) | (wd & lm)) & msk;
  endfunction

  assign fctl_nx = (wr && sel == SEL_FCTL) ? merge(fctl_q, bus_wdata, lane_m, FCTL_MASK)
                                           : fctl_q;
  assign tx_flush = wr && sel == SEL_FCTL && fctl_nx[FC_ENA] && fctl_nx[FC_TXCLR];
  assign rx_flush = wr && sel == SEL_FCTL && fctl_nx[FC_ENA] && fctl_nx[FC_RXCLR];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q <= LINE_RST;
      ien_q  <= '0;
      fctl_q <= '0;
      baud_q <= BAUD_RST;
    end else begin
      fctl_q <= fctl_nx;
      if (wr) begin
        case (sel)
          SEL_LINE: line_q <= merge(line_q, bus_wdata, lane_m, LINE_MASK);
          SEL_IEN:  ien_q  <= merge(ien_q, bus_wdata, lane_m, IEN_MASK);
          SEL_BAUD: baud_q <= merge(baud_q, bus_wdata, lane_m, BAUD_MASK);
          default:  ;
        endcase
      end
    end
  end

  assign flag_clr = (wr && sel == SEL_STAT)
                  ? (~bus_wdata[FLG_LO +: N_FLAGS] & lane_m[FLG_LO +: N_FLAGS])
                  : '0;
  assign ien      = ien_q[FLG_LO +: N_IEN];
  assign tx_push  = wr && sel == SEL_TXD && bus_be[LANES-1];
  assign tx_byte  = bus_wdata[DATA_W-1 -: 8];
  assign rx_pop   = rd && sel == SEL_RXD && bus_be[LANES-1] && !rx_empty;

  always_comb begin
    stat_word = '0;
    stat_word[FLG_LO +: N_FLAGS] = flags;
  end

  always_comb begin
    case (sel)
      SEL_LINE: rd_word = line_q;
      SEL_IEN:  rd_word = ien_q;
      SEL_STAT: rd_word = stat_word;
      SEL_FCTL: rd_word = fctl_q;
      SEL_BAUD: rd_word = baud_q;
      SEL_RXD:  rd_word = rx_empty ? '0 : {rx_head, {(DATA_W-8){1'b0}}};
      default:  rd_word = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  bus_rdata <= '0;
    else if (rd) bus_rdata <= rd_word & lane_m;
    else         bus_rdata <= '0;
  end
endmodule

// File: rtl/sio_regbank.sv
module sio_regbank
  import sio_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_en,
  input  logic        bus_we,
  input  logic [5:0]  bus_word,
  input  logic [3:0]  bus_be,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        tx_valid,
  input  logic        tx_ready,
  output logic [7:0]  tx_data,
  input  logic        rx_valid,
  output logic        rx_ready,
  input  logic [7:0]  rx_data,
  output logic        irq,
  output logic        dma_err
);
  logic [N_FLAGS-1:0] flags, flag_clr, flag_cond;
  logic [N_IEN-1:0]   ien;
  logic               tx_push, tx_flush, tx_empty, tx_full;
  logic               rx_pop, rx_flush, rx_empty, rx_full;
  logic [7:0]         tx_byte, rx_head;
  logic [CNT_W-1:0]   tx_count, rx_count;

  sio_csr u_csr (
    .clk(clk), .rst_n(rst_n),
    .bus_en(bus_en), .bus_we(bus_we), .bus_word(bus_word),
    .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .flags(flags), .flag_clr(flag_clr), .ien(ien),
    .tx_push(tx_push), .tx_byte(tx_byte), .tx_flush(tx_flush),
    .rx_empty(rx_empty), .rx_head(rx_head), .rx_pop(rx_pop),
    .rx_flush(rx_flush)
  );

  sio_fifo #(.WIDTH(8), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .flush(tx_flush),
    .push(tx_push), .push_data(tx_byte),
    .pop(tx_valid && tx_ready), .head(tx_data),
    .count(tx_count), .empty(tx_empty), .full(tx_full)
  );

  sio_fifo #(.WIDTH(8), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .flush(rx_flush),
    .push(rx_valid && rx_ready), .push_data(rx_data),
    .pop(rx_pop), .head(rx_head),
    .count(rx_count), .empty(rx_empty), .full(rx_full)
  );

  assign tx_valid  = !tx_empty;
  assign rx_ready  = !rx_full;
  // bit 0: receive data present, bit 1: transmit empty, bit 2: no hardware source
  assign flag_cond = {1'b0, tx_empty, !rx_empty};

  sio_flags #(.NF(N_FLAGS)) u_flags (
    .clk(clk), .rst_n(rst_n), .cond(flag_cond), .clr(flag_clr), .flag(flags)
  );

  assign irq     = |(flags & ien[N_FLAGS-1:0]);
  assign dma_err = ien[IEN_DMA - FLG_LO];

  logic unused_full;
  assign unused_full = tx_full;
endmodule

// File: rtl/sio_regbank_chk.sv
module sio_regbank_chk #(
  parameter int DEPTH = 16,
  parameter int CW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic [CW-1:0] rx_count,
  input logic [CW-1:0] tx_count,
  input logic          rx_ready,
  input logic          tx_valid,
  input logic          tx_ready,
  input logic [7:0]    tx_data,
  input logic          tx_flush,
  input logic          rx_pop,
  input logic [2:0]    flags,
  input logic [2:0]    flag_clr
);
  assert_rx_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_count == CW'(DEPTH) |-> !rx_ready);

  assert_tx_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready && !tx_flush |=> tx_valid && $stable(tx_data));

  assert_no_empty_pop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_pop |-> rx_count != '0);

  assert_rx_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_count != '0 && !flag_clr[0] |=> flags[0]);

  assert_tx_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_count == '0 && !flag_clr[1] |=> flags[1]);

  assert_clear_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flag_clr[0] |=> !flags[0]);
endmodule

bind sio_regbank sio_regbank_chk #(.DEPTH(FIFO_DEPTH), .CW(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_count(rx_count), .tx_count(tx_count),
  .rx_ready(rx_ready), .tx_valid(tx_valid), .tx_ready(tx_ready),
  .tx_data(tx_data), .tx_flush(tx_flush), .rx_pop(rx_pop),
  .flags(flags), .flag_clr(flag_clr)
);

// File: tb/sio_regbank_bench.sv
`timescale 1ns/1ps
module sio_regbank_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_en = 1'b0, bus_we = 1'b0;
  logic [5:0]  bus_word = '0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        tx_valid, rx_ready, irq, dma_err;
  logic        tx_ready = 1'b0, rx_valid = 1'b0;
  logic [7:0]  tx_data, rx_data = '0;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  sio_regbank u_sio_regbank (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_word(bus_word), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_data(rx_data), .irq(irq), .dma_err(dma_err)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic wr(input logic [5:0] w, input logic [31:0] d, input logic [3:0] be);
    bus_en = 1'b1; bus_we = 1'b1; bus_word = w; bus_wdata = d; bus_be = be;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] w, input logic [3:0] be, output logic [31:0] d);
    bus_en = 1'b1; bus_we = 1'b0; bus_word = w; bus_be = be;
    @(negedge clk);
    bus_en = 1'b0;
    d = bus_rdata;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  function automatic logic [31:0] exp_reset(input int w);
    case (w)
      0: return 32'h4000_0000;
      3: return 32'h0002_0000;
      5: return 32'h03FF_0000;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] exp_ones(input int w);
    case (w)
      0: return 32'hE17F_0000;
      2: return 32'h000F_0000;
      3: return 32'h0002_0000;
      4: return 32'h001F_0000;
      5: return 32'h03FF_0000;
      default: return 32'h0;
    endcase
  endfunction

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    @(negedge clk);
    do_reset();

    // R3 / R1: reset sweep over every word slot
    for (int w = 0; w < 64; w++) begin
      rd(6'(w), 4'hF, d);
      check($sformatf("R3 R1 reset word %0d", w), d, exp_reset(w));
    end
    check("R3 tx_valid idle", {31'b0, tx_valid}, 32'h0);
    check("R3 rx_ready idle", {31'b0, rx_ready}, 32'h1);
    check("R3 irq idle", {31'b0, irq}, 32'h0);

    // R2 / R1: all-ones write to every slot except the transmit word
    for (int w = 0; w < 64; w++)
      if (w != 8) wr(6'(w), 32'hFFFF_FFFF, 4'hF);
    for (int w = 0; w < 64; w++) begin
      rd(6'(w), 4'hF, d);
      check($sformatf("R2 R1 mask word %0d", w), d, exp_ones(w));
    end
    check("R10 irq tx-empty enabled", {31'b0, irq}, 32'h1);
    check("R11 dma_err set", {31'b0, dma_err}, 32'h1);
    wr(6'd2, 32'h0, 4'hF);
    check("R10 irq disabled", {31'b0, irq}, 32'h0);
    check("R11 dma_err clear", {31'b0, dma_err}, 32'h0);

    do_reset();
    // R4: byte lanes
    wr(6'd5, 32'hFF12_0000, 4'b0100);
    rd(6'd5, 4'hF, d);   check("R4 lane2 write", d, 32'h0312_0000);
    rd(6'd5, 4'b1000, d); check("R4 lane3 read", d, 32'h0300_0000);
    rd(6'd5, 4'b0100, d); check("R4 lane2 read", d, 32'h0012_0000);

    // R5: other lanes of transmit word ignored, word reads zero
    wr(6'd8, 32'hFFFF_FFFF, 4'b0111);
    check("R5 no push on low lanes", {31'b0, tx_valid}, 32'h0);
    // R5 / R7: push 20, only 16 kept
    for (int i = 0; i < 20; i++) wr(6'd8, {8'(8'h30 + i), 24'h0}, 4'b1000);
    rd(6'd8, 4'hF, d); check("R5 tx word reads zero", d, 32'h0);
    repeat (3) @(negedge clk);
    check("R5 held head", {24'b0, tx_data}, 32'h30);
    tx_ready = 1'b1;
    for (int i = 0; i < 16; i++) begin
      check($sformatf("R5 R7 tx byte %0d", i), {23'b0, tx_valid, tx_data},
            {23'b0, 1'b1, 8'(8'h30 + i)});
      @(negedge clk);
    end
    check("R7 tx excess dropped", {31'b0, tx_valid}, 32'h0);
    tx_ready = 1'b0;

    // R7: fill receive FIFO with 20 offers
    for (int i = 0; i < 20; i++) begin
      check($sformatf("R7 rx_ready at %0d", i), {31'b0, rx_ready}, {31'b0, i < 16});
      rx_valid = 1'b1; rx_data = 8'(8'h50 + i);
      @(negedge clk);
    end
    rx_valid = 1'b0;
    @(negedge clk);

    // R8 / R9: sticky flags and clear-on-zero
    rd(6'd3, 4'hF, d); check("R8 both flags", d, 32'h0003_0000);
    wr(6'd3, 32'h0002_0000, 4'b0100);
    rd(6'd3, 4'hF, d); check("R9 cleared one cycle", d, 32'h0002_0000);
    rd(6'd3, 4'hF, d); check("R9 re-set while data", d, 32'h0003_0000);
    wr(6'd3, 32'h0, 4'b1011);
    rd(6'd3, 4'hF, d); check("R9 disabled lane keeps", d, 32'h0003_0000);

    // R10: receive interrupt
    wr(6'd2, 32'h0001_0000, 4'b0100);
    check("R10 irq rx", {31'b0, irq}, 32'h1);

    // R6: pops
    rd(6'd12, 4'b0111, d); check("R6 low lanes no pop", d, 32'h0);
    for (int i = 0; i < 16; i++) begin
      rd(6'd12, 4'b1000, d);
      check($sformatf("R6 rx byte %0d", i), d, {8'(8'h50 + i), 24'h0});
    end
    rd(6'd12, 4'hF, d); check("R6 empty reads zero", d, 32'h0);
    check("R8 flag sticky after drain", {31'b0, irq}, 32'h1);
    wr(6'd3, 32'h0002_0000, 4'b0100);
    check("R10 irq drops on clear", {31'b0, irq}, 32'h0);
    rd(6'd3, 4'hF, d); rd(6'd3, 4'hF, d);
    check("R9 stays clear", d, 32'h0002_0000);
    wr(6'd2, 32'h0003_0000, 4'b0100);
    check("R10 irq tx-empty", {31'b0, irq}, 32'h1);
    wr(6'd2, 32'h0008_0000, 4'b0100);
    check("R11 dma_err", {30'b0, dma_err, irq}, 32'h2);
    wr(6'd2, 32'h0, 4'b0100);

    // R12: flush gating
    for (int i = 0; i < 3; i++) wr(6'd8, 32'hA500_0000, 4'b1000);
    wr(6'd4, 32'h0004_0000, 4'b0100);
    check("R12 no flush without enable", {31'b0, tx_valid}, 32'h1);
    wr(6'd4, 32'h0005_0000, 4'b0100);
    check("R12 tx flushed", {31'b0, tx_valid}, 32'h0);
    rx_valid = 1'b1; rx_data = 8'h77;
    repeat (2) @(negedge clk);
    rx_valid = 1'b0;
    wr(6'd4, 32'h0003_0000, 4'b0100);
    rd(6'd12, 4'b1000, d); check("R12 rx flushed", d, 32'h0);
    rd(6'd4, 4'hF, d); check("R12 control readback", d, 32'h0003_0000);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule